// File: doc/BRIEF.md
# Receive Frame Buffer with CRC Commit

This block sits behind the receive half of a GMII link. It removes the preamble and the start-of-frame delimiter from each incoming frame. It packs the remaining bytes into memory words and runs the Ethernet CRC-32 over them as they arrive.

Each frame is written into the ring memory speculatively, ahead of a committed pointer that the reader cannot pass. When the receive-valid strobe drops, the block decides the fate of the frame:
- If the residue checks good, the committed pointer moves past the frame, and the frame becomes readable as a whole.
- Otherwise the write pointer is wound back to the committed pointer, and the frame leaves no trace.

A frame that runs out of room is treated the same way, and the block counts it as a drop.

The reader sees a FIFO-style port: a valid flag, the word at the head, markers for the first and last word of a frame, and a byte count. The reader pulls each word with a one-cycle read strobe. The stored bytes include the four FCS bytes, so a client can strip or forward them as it prefers.

Top module: `gmrx_commit_buf`

## Requirements
- R1: After reset `rd_valid` is 0 and `drop_count` is 0.
- R2: A frame is accepted only when it opens with one or more 0x55 bytes followed by 0xD5. Neither kind of byte is stored. A burst whose first byte is not 0x55 stores nothing until `gmii_rx_dv` falls.
- R3: A frame is kept when the CRC-32 register over every byte after 0xD5 ends at 0xDEBB20E3. The CRC uses reflected polynomial 0xEDB88320 and starts from all ones, with no final inversion. The stored bytes are all bytes after 0xD5, FCS included and in arrival order. Byte k of a word sits in `rd_data[8k+7:8k]`, with LANES=4 bytes per word.
- R4: `rd_sop` is 1 on the first word of each frame. `rd_eop` is 1 on its last word. `rd_cnt` gives the number of valid bytes, which is 4 on full words and 1 to 4 on the last word. Unused lanes read as zero.
- R5: A frame whose CRC residue is wrong never produces a word on the read side.
- R6: A frame during which `gmii_rx_er` is 1 on any data byte is discarded, even if its CRC is good.
- R7: No word of a frame becomes visible before that frame has ended and passed its check. While a frame is still arriving into an empty buffer, `rd_valid` stays 0.
- R8: If a word of a frame finds the memory full, that frame is discarded and `drop_count` rises by one. Frames committed earlier are read back intact, and later frames are accepted normally. CRC and error discards do not change `drop_count`.
- R9: The word at the head stays stable while `rd_valid` is 1 and `rd_en` is 0. A high `rd_en` while `rd_valid` is 0 has no effect.
- R10: Frames separated by a single idle cycle are each judged on their own. Good ones are read out in arrival order, with discarded ones missing from the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gmii_rxd | input | 8 | Receive data byte |
| gmii_rx_dv | input | 1 | Receive data valid |
| gmii_rx_er | input | 1 | Receive error |
| rd_en | input | 1 | Pop the head word |
| rd_valid | output | 1 | A committed word is at the head |
| rd_data | output | 32 | Head word, byte k in lane k |
| rd_sop | output | 1 | Head word starts a frame |
| rd_eop | output | 1 | Head word ends a frame |
| rd_cnt | output | 3 | Valid bytes in head word |
| drop_count | output | 16 | Frames lost to a full memory |

## Verification
The hardest situation to reach is an overflow that lands in the middle of a frame while an earlier good frame is still committed, unread, in the same ring.

The bench stalls its reader and lands a short good frame. It then sends a frame longer than the remaining space, and only afterwards lets the reader drain. This shows three things: the rollback stops exactly at the committed boundary, the counter moves once, and a later frame still fits.

Frame lengths are chosen so that every value of the final byte count occurs.

// File: rtl/gmrx_pkg.sv
package gmrx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_BODY, ST_SKIP} rx_state_e;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_GOOD = 32'hDEBB20E3;
  localparam logic [7:0]  PRE_BYTE = 8'h55;
  localparam logic [7:0]  SFD_BYTE = 8'hD5;

  function automatic logic [31:0] crc_step(logic [31:0] c, logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/gmrx_crc32.sv
module gmrx_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  import gmrx_pkg::*;
  logic [31:0] crc_d;

  always_comb begin
    crc_d = crc_q;
    if (init)    crc_d = CRC_SEED;
    else if (en) crc_d = crc_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         crc_q <= CRC_SEED;
    else if (init | en) crc_q <= crc_d;
  end
endmodule

// File: rtl/gmrx_framer.sv
module gmrx_framer #(
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  localparam int CW  = $clog2(LANES + 1),
  localparam int DW8 = LANES * 8,
  localparam int WW  = DW8 + CW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       rxd,
  input  logic             rx_dv,
  input  logic             rx_er,
  input  logic             full,
  output logic             push,
  output logic [WW-1:0]    push_word,
  output logic             fin_good,
  output logic             fin_bad,
  output logic [CNT_W-1:0] drop_count
);
  import gmrx_pkg::*;
  localparam logic [CW-1:0] FULL_CNT = CW'(LANES);

  rx_state_e        st_q, st_d;
  logic [DW8-1:0]   stage_q, stage_d;
  logic [CW-1:0]    lane_q, lane_d, push_cnt;
  logic             first_q, first_d, err_q, err_d, ovf_q, ovf_d;
  logic             push_req, push_eop, ovf_now, crc_init, crc_en, drop_inc;
  logic [31:0]      crc_q;

  gmrx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .en(crc_en),
    .din(rxd), .crc_q(crc_q)
  );

  always_comb begin
    st_d = st_q;  stage_d = stage_q;  lane_d = lane_q;
    first_d = first_q;  err_d = err_q;  ovf_d = ovf_q;
    push_req = 1'b0;  push_eop = 1'b0;  push_cnt = lane_q;
    crc_init = 1'b0;  crc_en = 1'b0;
    fin_good = 1'b0;  fin_bad = 1'b0;
    case (st_q)
      ST_IDLE: if (rx_dv) st_d = (rxd == PRE_BYTE) ? ST_PRE : ST_SKIP;
      ST_PRE: begin
        if (!rx_dv) st_d = ST_IDLE;
        else if (rxd == SFD_BYTE) begin
          st_d = ST_BODY;  crc_init = 1'b1;  lane_d = '0;
          first_d = 1'b1;  err_d = 1'b0;  ovf_d = 1'b0;  stage_d = '0;
        end else if (rxd != PRE_BYTE) st_d = ST_SKIP;
      end
      ST_BODY: begin
        if (rx_dv) begin
          crc_en = 1'b1;
          if (rx_er) err_d = 1'b1;
          if (lane_q == FULL_CNT) begin
            push_req = !ovf_q;
            push_cnt = FULL_CNT;
            stage_d  = {{(DW8-8){1'b0}}, rxd};
            lane_d   = CW'(1);
          end else begin
            for (int i = 0; i < LANES; i++) begin
              if (lane_q == CW'(i)) stage_d[8*i +: 8] = rxd;
            end
            lane_d = lane_q + CW'(1);
          end
        end else begin
          st_d = ST_IDLE;
          push_req = (lane_q != '0) && !ovf_q;
          push_eop = 1'b1;
        end
      end
      default: if (!rx_dv) st_d = ST_IDLE;
    endcase
    ovf_now = ovf_q | (push_req & full);
    if (push_req) first_d = 1'b0;
    if (push_req && full) ovf_d = 1'b1;
    if (st_q == ST_BODY && !rx_dv) begin
      fin_good = !err_q && !ovf_now && (lane_q != '0) && (crc_q == CRC_GOOD);
      fin_bad  = !fin_good;
    end
  end

  assign push      = push_req & ~full;
  assign push_word = {first_q, push_eop, push_cnt, stage_q};
  assign drop_inc  = fin_bad & ovf_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  stage_q <= '0;  lane_q <= '0;
      first_q <= 1'b0;  err_q <= 1'b0;  ovf_q <= 1'b0;
    end else begin
      st_q <= st_d;  stage_q <= stage_d;  lane_q <= lane_d;
      first_q <= first_d;  err_q <= err_d;  ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        drop_count <= '0;
    else if (drop_inc) drop_count <= drop_count + CNT_W'(1);
  end
endmodule

// File: rtl/gmrx_ring.sv
module gmrx_ring #(
  parameter int DEPTH = 32,
  parameter int WW    = 37,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [WW-1:0] push_word,
  input  logic          fin_good,
  input  logic          fin_bad,
  input  logic          rd_en,
  output logic          full,
  output logic          rd_valid,
  output logic [WW-1:0] rd_word
);
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [WW-1:0] mem [DEPTH];
  logic [AW:0]   wr_q, wr_d, cm_q, cm_d, rd_q, rd_d;

  assign full     = (wr_q - rd_q) == FULL_LVL;
  assign rd_valid = rd_q != cm_q;
  assign rd_word  = mem[rd_q[AW-1:0]];

  always_comb begin
    wr_d = push ? wr_q + (AW+1)'(1) : wr_q;
    cm_d = cm_q;
    if (fin_good) cm_d = wr_d;
    if (fin_bad)  wr_d = cm_q;
    rd_d = (rd_en && rd_valid) ? rd_q + (AW+1)'(1) : rd_q;
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q[AW-1:0]] <= push_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q <= '0;  cm_q <= '0;  rd_q <= '0;
    end else begin
      wr_q <= wr_d;  cm_q <= cm_d;  rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/gmrx_commit_buf.sv
module gmrx_commit_buf #(
  parameter int LANES = 4,
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int CW   = $clog2(LANES + 1),
  localparam int DW8  = LANES * 8,
  localparam int WW   = DW8 + CW + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       gmii_rxd,
  input  logic             gmii_rx_dv,
  input  logic             gmii_rx_er,
  input  logic             rd_en,
  output logic             rd_valid,
  output logic [DW8-1:0]   rd_data,
  output logic             rd_sop,
  output logic             rd_eop,
  output logic [CW-1:0]    rd_cnt,
  output logic [CNT_W-1:0] drop_count
);
  logic [1:0]    rst_pipe;
  logic          rst_q_n, push, full, fin_good, fin_bad;
  logic [WW-1:0] push_word, rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  gmrx_framer #(.LANES(LANES), .CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_q_n), .rxd(gmii_rxd), .rx_dv(gmii_rx_dv),
    .rx_er(gmii_rx_er), .full(full), .push(push), .push_word(push_word),
    .fin_good(fin_good), .fin_bad(fin_bad), .drop_count(drop_count)
  );

  gmrx_ring #(.DEPTH(DEPTH), .WW(WW)) u_ring (
    .clk(clk), .rst_n(rst_q_n), .push(push), .push_word(push_word),
    .fin_good(fin_good), .fin_bad(fin_bad), .rd_en(rd_en),
    .full(full), .rd_valid(rd_valid), .rd_word(rd_word)
  );

  assign {rd_sop, rd_eop, rd_cnt, rd_data} = rd_word;
endmodule

// File: rtl/gmrx_commit_buf_chk.sv
module gmrx_commit_buf_chk #(
  parameter int LANES = 4,
  parameter int CNT_W = 16,
  localparam int CW   = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_q_n,
  input logic             fin_good,
  input logic             fin_bad,
  input logic             rd_en,
  input logic             rd_valid,
  input logic [LANES*8-1:0] rd_data,
  input logic             rd_eop,
  input logic [CW-1:0]    rd_cnt,
  input logic [CNT_W-1:0] drop_count
);
  // R5
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(fin_good && fin_bad));

  // R7
  visible_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(rd_valid) |-> $past(fin_good));

  // R9
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data) && $stable(rd_eop)));

  // R4
  last_count_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_valid && rd_eop) |-> (rd_cnt != '0 && rd_cnt <= CW'(LANES)));

  // R8
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (drop_count == $past(drop_count) || drop_count == $past(drop_count) + CNT_W'(1)));
endmodule

bind gmrx_commit_buf gmrx_commit_buf_chk #(.LANES(LANES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .fin_good(fin_good), .fin_bad(fin_bad),
  .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eop(rd_eop),
  .rd_cnt(rd_cnt), .drop_count(drop_count)
);

// File: tb/gmrx_commit_buf_test.sv
module gmrx_commit_buf_test;
  logic        clk, rst_n;
  logic [7:0]  gmii_rxd;
  logic        gmii_rx_dv, gmii_rx_er, rd_en;
  logic        rd_valid, rd_sop, rd_eop;
  logic [31:0] rd_data;
  logic [2:0]  rd_cnt;
  logic [15:0] drop_count;

  typedef struct packed { logic sop; logic eop; logic [2:0] cnt; logic [31:0] data; } exp_t;
  exp_t exp_q[$];
  int   checks = 0, errors = 0;
  bit   rd_go = 1, poke = 0, started = 0;

  gmrx_commit_buf uut (.*);

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_crc(input logic [7:0] b[$]);
    logic [31:0] c = 32'hFFFF_FFFF;
    foreach (b[k]) begin
      c ^= {24'h0, b[k]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] b, input logic dv, input logic er);
    @(negedge clk);
    gmii_rxd = b; gmii_rx_dv = dv; gmii_rx_er = er;
  endtask

  // scoreboard driver: frame on the wire, expected words into the queue
  task automatic send(input int len, input int seed, input bit bad_fcs, input int er_at,
                      input bit no_pre, input bit expect_ok, input bit chk_hidden, input int gap);
    logic [7:0] f[$];
    logic [31:0] c;
    for (int i = 0; i < len; i++) f.push_back(8'((i * 7 + seed) & 8'hFF));
    c = ~ref_crc(f);
    for (int i = 0; i < 4; i++) f.push_back(c[8*i +: 8]);
    if (bad_fcs) f[f.size()-1] ^= 8'h01;
    if (no_pre) drive(8'hAA, 1, 0);
    else begin
      for (int i = 0; i < 7; i++) drive(8'h55, 1, 0);
      drive(8'hD5, 1, 0);
    end
    foreach (f[k]) drive(f[k], 1, (k == er_at));
    if (chk_hidden) begin
      @(negedge clk);
      check(rd_valid == 0, "R7 visible mid-frame", 64'(rd_valid), 0);
      gmii_rx_dv = 0; gmii_rx_er = 0;
    end else drive(8'h00, 0, 0);
    if (expect_ok) begin
      for (int i = 0; i < f.size(); i += 4) begin
        exp_t e;
        e.data = '0;
        e.cnt  = 3'((f.size() - i) >= 4 ? 4 : f.size() - i);
        for (int j = 0; j < 4; j++) if (j < int'(e.cnt)) e.data[8*j +: 8] = f[i+j];
        e.sop = (i == 0);
        e.eop = (i + 4 >= f.size());
        exp_q.push_back(e);
      end
    end
    for (int i = 0; i < gap; i++) drive(8'h00, 0, 0);
  endtask

  task automatic drain();
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || rd_valid); i++) @(negedge clk);
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0 && !rd_valid, "R3 drain", 64'(exp_q.size()), 0);
  endtask

  // monitor
  initial begin
    rd_en = 0;
    forever begin
      @(negedge clk);
      if (started && rd_valid && rd_go) begin
        if (exp_q.size() == 0) begin
          check(0, "R5 unexpected word", 64'(rd_data), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check({rd_sop, rd_eop, rd_cnt, rd_data} == e, "R3/R4 word",
                64'({rd_sop, rd_eop, rd_cnt, rd_data}), 64'(e));
        end
        rd_en = 1;
      end else rd_en = poke;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; gmii_rxd = 0; gmii_rx_dv = 0; gmii_rx_er = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(rd_valid == 0, "R1 rd_valid", 64'(rd_valid), 0);
    check(drop_count == 0, "R1 drop_count", 64'(drop_count), 0);
    started = 1;
    // R9 read strobe on empty buffer is ignored
    poke = 1; repeat (8) @(negedge clk); poke = 0;
    check(rd_valid == 0, "R9 empty pop", 64'(rd_valid), 0);
    // R7 + R3 first frame, hidden until its end
    send(60, 1, 0, -1, 0, 1, 1, 12);
    // R4 every tail count
    send(61, 2, 0, -1, 0, 1, 0, 12);
    send(62, 3, 0, -1, 0, 1, 0, 12);
    send(63, 4, 0, -1, 0, 1, 0, 12);
    drain();
    // R5 bad FCS, R6 error strobe, R2 missing preamble
    send(50, 5, 1, -1, 0, 0, 0, 12);
    send(50, 6, 0, 20, 0, 0, 0, 12);
    send(50, 7, 0, -1, 1, 0, 0, 12);
    repeat (10) @(negedge clk);
    check(rd_valid == 0, "R5/R6/R2 nothing stored", 64'(rd_valid), 0);
    check(drop_count == 0, "R8 no count on crc/err", 64'(drop_count), 0);
    // R10 back to back, bad one in the middle
    send(45, 8, 0, -1, 0, 1, 0, 1);
    send(46, 9, 1, -1, 0, 0, 0, 1);
    send(47, 10, 0, -1, 0, 1, 0, 1);
    drain();
    // R8 overflow with a committed frame waiting
    rd_go = 0;
    send(40, 11, 0, -1, 0, 1, 0, 12);
    send(120, 12, 0, -1, 0, 0, 0, 12);
    repeat (4) @(negedge clk);
    check(drop_count == 1, "R8 drop_count", 64'(drop_count), 1);
    check(rd_valid == 1 && rd_sop == 1, "R9 head held", 64'({rd_valid, rd_sop}), 3);
    rd_go = 1;
    drain();
    send(21, 13, 0, -1, 0, 1, 0, 12);
    drain();
    check(drop_count == 1, "R8 later frame accepted", 64'(drop_count), 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule